// File: doc/BRIEF.md
# Low-Address Guard and Prefix Remapper

This block sits in the storage-access path of a processor, after any address translation. Each cycle it may accept one request made of a real byte address, an access kind, an address-space selector, the translation-enable state and a few control bits. One cycle later it returns a verdict. The verdict holds either a permitted access with its absolute address and a read/write/execute permission vector, a protection exception for a store into a guarded low window, or an unsupported-mode error.

Two low windows of 512 bytes are guarded: the first 512 bytes of page 0 and the first 512 bytes of page 1. Guarding is switched on by an enable bit. When translation is on, a private-space bit belonging to the selected address space can also switch it off. A store whose exact address falls in a guarded window is refused. Any access whose 4 KB page holds a guarded window has a hint set, so that cached write permission for that page is checked again later.

Address remapping uses a prefix register that software writes through a one-cycle write port. The 8 KB block at address zero and the 8 KB block at the prefix trade places. All other addresses pass through unchanged.

Top module: `lowprot_prefix_unit`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_prot_exc, rsp_wr_recheck, rsp_bad_mode are 0, rsp_perm is 3'b000, rsp_abs_addr is 0, and the prefix register is 0, so a later load to 0x100 returns absolute 0x100.
- R2: rsp_valid equals req_valid of the previous cycle. All response fields are registered with exactly one cycle of latency.
- R3: A real address below 0x2000 maps to address + prefix.
- R4: A real address at or above the prefix and below prefix + 0x2000 (and not below 0x2000) maps to address - prefix.
- R5: Any other real address passes to rsp_abs_addr unchanged.
- R6: A prefix write (pfx_we=1) discards bits 12:0 of pfx_wdata. A request presented in the same cycle as the write still uses the old prefix; a request in the next cycle uses the new one.
- R7: With lap_en=0 no request raises rsp_prot_exc or rsp_wr_recheck.
- R8: With lap_en=1 and dat_on=0, guarding applies whatever the space selector and private-space bits are.
- R9: With lap_en=1 and dat_on=1, guarding applies only if the private-space bit of the selected space is 0. Encoding of req_space: 0 primary (priv_primary), 2 secondary (priv_secondary), 3 home (priv_home).
- R10: A store (req_kind=1) whose address is in 0..511 or 4096..4607 while guarding applies gives rsp_prot_exc=1 with a zero exception code. The store is not performed: rsp_perm=3'b000 and rsp_abs_addr=0. Loads (0), fetches (2) and code 3 never raise it.
- R11: While guarding applies, a request whose 4 KB-aligned address is 0 or 4096 returns rsp_wr_recheck=1. This also holds for permitted accesses, such as a store at 512 or a load at 0.
- R12: A response with no exception and no mode error carries full permissions, rsp_perm=3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R13: With dat_on=1 and req_space=1 (access-register mode) the response has rsp_bad_mode=1, rsp_perm=3'b000, rsp_abs_addr=0, rsp_prot_exc=0 and rsp_wr_recheck=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Real byte address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_space | input | 2 | 0 primary, 1 access-register, 2 secondary, 3 home |
| dat_on | input | 1 | Address translation enabled |
| lap_en | input | 1 | Low-address guard enable |
| priv_primary | input | 1 | Private-space bit of the primary space |
| priv_secondary | input | 1 | Private-space bit of the secondary space |
| priv_home | input | 1 | Private-space bit of the home space |
| pfx_we | input | 1 | Prefix register write strobe |
| pfx_wdata | input | ADDR_W | Prefix value (bits 12:0 dropped) |
| rsp_valid | output | 1 | Response present |
| rsp_abs_addr | output | ADDR_W | Absolute address |
| rsp_perm | output | 3 | Permissions: bit 0 read, 1 write, 2 execute |
| rsp_wr_recheck | output | 1 | Do not reuse cached write permission |
| rsp_prot_exc | output | 1 | Protection exception, code zero |
| rsp_bad_mode | output | 1 | Unsupported address-space mode |

## Verification
A wrong enable or window decision inside the guard appears on the very next response. It shows up as a stray or missing rsp_prot_exc, a zeroed permission vector, or a hint bit that disagrees with the page of the request. A corrupted prefix register stays hidden until a request lands in one of the two swapped 8 KB blocks. The vector table therefore places addresses at both edges of each block, and the directed tests move the prefix and probe the write-to-use timing in adjacent cycles.

// File: rtl/lapx_pkg.sv
package lapx_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SPC_PRIMARY   = 2'd0,
    SPC_AREG      = 2'd1,
    SPC_SECONDARY = 2'd2,
    SPC_HOME      = 2'd3
  } space_e;

  localparam int PERM_W_BITS = 3;

  typedef struct packed {
    logic                   exc;
    logic                   recheck;
    logic                   bad;
    logic [PERM_W_BITS-1:0] perm;
  } verdict_t;

endpackage

// File: rtl/lapx_guard.sv
module lapx_guard
  import lapx_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int WIN_BYTES = 512,
  parameter int WIN1_BASE = 4096,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_kind_e         kind,
  input  space_e            space,
  input  logic              dat_on,
  input  logic              lap_en,
  input  logic              priv_p,
  input  logic              priv_s,
  input  logic              priv_h,
  output verdict_t          verdict
);

  localparam logic [ADDR_W-1:0] W0_LIMIT = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] W1_LO    = ADDR_W'(WIN1_BASE);
  localparam logic [ADDR_W-1:0] W1_LIMIT = ADDR_W'(WIN1_BASE + WIN_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MSK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a < W0_LIMIT) || ((a >= W1_LO) && (a < W1_LIMIT));
  endfunction

  logic priv_sel;
  logic bad_mode;
  logic guard_on;
  logic hit_exact;
  logic hit_page;

  always_comb begin
    unique case (space)
      SPC_SECONDARY: priv_sel = priv_s;
      SPC_HOME:      priv_sel = priv_h;
      default:       priv_sel = priv_p;
    endcase
    bad_mode  = dat_on && (space == SPC_AREG);
    guard_on  = lap_en && !bad_mode && (!dat_on || !priv_sel);
    hit_exact = in_window(addr);
    hit_page  = in_window(addr & PAGE_MSK);

    verdict.bad     = bad_mode;
    verdict.exc     = guard_on && hit_exact && (kind == ACC_STORE);
    verdict.recheck = guard_on && hit_page;
    verdict.perm    = (verdict.exc || bad_mode) ? '0 : '1;
  end

endmodule

// File: rtl/lapx_prefix.sv
module lapx_prefix #(
  parameter int ADDR_W    = 64,
  parameter int SPAN_BITS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] abs_addr
);

  localparam logic [ADDR_W-1:0] ALIGN_MSK = ~((ADDR_W'(1) << SPAN_BITS) - ADDR_W'(1));
  localparam logic [ADDR_W:0]   SPAN_EXT  = (ADDR_W+1)'(1) << SPAN_BITS;

  logic [ADDR_W-1:0] prefix_q;
  logic [ADDR_W:0]   upper_ext;
  logic              in_low;
  logic              in_pfx;

  always_ff @(posedge clk) begin
    if (rst) begin
      prefix_q <= '0;
    end else if (we) begin
      prefix_q <= wdata & ALIGN_MSK;
    end
  end

  always_comb begin
    upper_ext = {1'b0, prefix_q} + SPAN_EXT;
    in_low    = {1'b0, addr} < SPAN_EXT;
    in_pfx    = (addr >= prefix_q) && ({1'b0, addr} < upper_ext);
    if (in_low) begin
      abs_addr = addr + prefix_q;
    end else if (in_pfx) begin
      abs_addr = addr - prefix_q;
    end else begin
      abs_addr = addr;
    end
  end

endmodule

// File: rtl/lowprot_prefix_unit.sv
module lowprot_prefix_unit
  import lapx_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int WIN_BYTES = 512,
  parameter int WIN1_BASE = 4096,
  parameter int PAGE_BITS = 12,
  parameter int SPAN_BITS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_space,
  input  logic              dat_on,
  input  logic              lap_en,
  input  logic              priv_primary,
  input  logic              priv_secondary,
  input  logic              priv_home,
  input  logic              pfx_we,
  input  logic [ADDR_W-1:0] pfx_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_abs_addr,
  output logic [2:0]        rsp_perm,
  output logic              rsp_wr_recheck,
  output logic              rsp_prot_exc,
  output logic              rsp_bad_mode
);

  verdict_t          verdict;
  logic [ADDR_W-1:0] mapped;

  lapx_guard #(
    .ADDR_W   (ADDR_W),
    .WIN_BYTES(WIN_BYTES),
    .WIN1_BASE(WIN1_BASE),
    .PAGE_BITS(PAGE_BITS)
  ) i_guard (
    .addr   (req_addr),
    .kind   (acc_kind_e'(req_kind)),
    .space  (space_e'(req_space)),
    .dat_on (dat_on),
    .lap_en (lap_en),
    .priv_p (priv_primary),
    .priv_s (priv_secondary),
    .priv_h (priv_home),
    .verdict(verdict)
  );

  lapx_prefix #(
    .ADDR_W   (ADDR_W),
    .SPAN_BITS(SPAN_BITS)
  ) i_prefix (
    .clk     (clk),
    .rst     (rst),
    .we      (pfx_we),
    .wdata   (pfx_wdata),
    .addr    (req_addr),
    .abs_addr(mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_abs_addr   <= '0;
      rsp_perm       <= '0;
      rsp_wr_recheck <= 1'b0;
      rsp_prot_exc   <= 1'b0;
      rsp_bad_mode   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_abs_addr   <= (verdict.exc || verdict.bad) ? '0 : mapped;
        rsp_perm       <= verdict.perm;
        rsp_wr_recheck <= verdict.recheck;
        rsp_prot_exc   <= verdict.exc;
        rsp_bad_mode   <= verdict.bad;
      end
    end
  end

endmodule

// File: rtl/lapx_checker.sv
module lapx_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic [1:0]        req_space,
  input logic              dat_on,
  input logic              lap_en,
  input logic              rsp_valid,
  input logic [2:0]        rsp_perm,
  input logic              rsp_wr_recheck,
  input logic              rsp_prot_exc,
  input logic              rsp_bad_mode
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r7_guard_off: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !lap_en) |=> (!rsp_prot_exc && !rsp_wr_recheck));

  a_r10_store_only: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'd1) |=> !rsp_prot_exc);

  a_r10_refused: assert property (@(posedge clk) disable iff (rst)
    rsp_prot_exc |-> (rsp_perm == 3'b000 && rsp_wr_recheck));

  a_r12_full_perm: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_prot_exc && !rsp_bad_mode) |-> rsp_perm == 3'b111);

  a_r13_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dat_on && req_space == 2'd1) |=>
      (rsp_bad_mode && !rsp_prot_exc && rsp_perm == 3'b000));

  a_r11_far_no_hint: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= ADDR_W'(8192)) |=> !rsp_wr_recheck);

endmodule

bind lowprot_prefix_unit lapx_checker #(.ADDR_W(ADDR_W)) i_lapx_checker (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_kind      (req_kind),
  .req_space     (req_space),
  .dat_on        (dat_on),
  .lap_en        (lap_en),
  .rsp_valid     (rsp_valid),
  .rsp_perm      (rsp_perm),
  .rsp_wr_recheck(rsp_wr_recheck),
  .rsp_prot_exc  (rsp_prot_exc),
  .rsp_bad_mode  (rsp_bad_mode)
);

// File: tb/test_lowprot_prefix_unit.sv
module test_lowprot_prefix_unit;

  localparam int ADDR_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_kind = 2'd0;
  logic [1:0]        req_space = 2'd0;
  logic              dat_on = 1'b0;
  logic              lap_en = 1'b0;
  logic              priv_primary = 1'b0;
  logic              priv_secondary = 1'b0;
  logic              priv_home = 1'b0;
  logic              pfx_we = 1'b0;
  logic [ADDR_W-1:0] pfx_wdata = '0;
  logic              rsp_valid;
  logic [ADDR_W-1:0] rsp_abs_addr;
  logic [2:0]        rsp_perm;
  logic              rsp_wr_recheck;
  logic              rsp_prot_exc;
  logic              rsp_bad_mode;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lowprot_prefix_unit #(.ADDR_W(ADDR_W)) i_lowprot_prefix_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_space(req_space), .dat_on(dat_on),
    .lap_en(lap_en), .priv_primary(priv_primary),
    .priv_secondary(priv_secondary), .priv_home(priv_home),
    .pfx_we(pfx_we), .pfx_wdata(pfx_wdata), .rsp_valid(rsp_valid),
    .rsp_abs_addr(rsp_abs_addr), .rsp_perm(rsp_perm),
    .rsp_wr_recheck(rsp_wr_recheck), .rsp_prot_exc(rsp_prot_exc),
    .rsp_bad_mode(rsp_bad_mode)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  space;
    logic        dat;
    logic        lap;
    logic        pp;
    logic        ps;
    logic        ph;
    logic [31:0] addr;
    logic        e_exc;
    logic        e_rc;
    logic        e_bad;
    logic [2:0]  e_perm;
    logic [31:0] e_abs;
  } vec_t;

  // kind space dat lap pp ps ph addr | exc rc bad perm abs ; prefix 0x6000
  localparam vec_t VECS [19] = '{
    '{2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0100, 1'b0,1'b0,1'b0,3'b111,32'h6100}, // R3 R7
    '{2'd1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0100, 1'b1,1'b1,1'b0,3'b000,32'h0000}, // R10
    '{2'd1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0200, 1'b0,1'b1,1'b0,3'b111,32'h6200}, // R11
    '{2'd0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h1000, 1'b0,1'b1,1'b0,3'b111,32'h7000}, // R11
    '{2'd1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h11FF, 1'b1,1'b1,1'b0,3'b000,32'h0000}, // R10
    '{2'd1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h1200, 1'b0,1'b1,1'b0,3'b111,32'h7200}, // R11
    '{2'd1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h2000, 1'b0,1'b0,1'b0,3'b111,32'h2000}, // R5 R12
    '{2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h6010, 1'b0,1'b0,1'b0,3'b111,32'h0010}, // R4
    '{2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7FFF, 1'b0,1'b0,1'b0,3'b111,32'h1FFF}, // R4
    '{2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h8000, 1'b0,1'b0,1'b0,3'b111,32'h8000}, // R5
    '{2'd1,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0010, 1'b0,1'b0,1'b0,3'b111,32'h6010}, // R9
    '{2'd1,2'd0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h0010, 1'b1,1'b1,1'b0,3'b000,32'h0000}, // R9
    '{2'd1,2'd2,1'b1,1'b1,1'b0,1'b1,1'b0,32'h0010, 1'b0,1'b0,1'b0,3'b111,32'h6010}, // R9
    '{2'd1,2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,32'h0010, 1'b1,1'b1,1'b0,3'b000,32'h0000}, // R9
    '{2'd1,2'd3,1'b1,1'b1,1'b0,1'b0,1'b1,32'h0010, 1'b0,1'b0,1'b0,3'b111,32'h6010}, // R9
    '{2'd0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0040, 1'b0,1'b0,1'b1,3'b000,32'h0000}, // R13
    '{2'd1,2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,32'h0010, 1'b1,1'b1,1'b0,3'b000,32'h0000}, // R8
    '{2'd2,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0000, 1'b0,1'b1,1'b0,3'b111,32'h6000}, // R11
    '{2'd1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0010, 1'b0,1'b0,1'b0,3'b111,32'h6010}  // R7
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [1:0] space,
                       input logic dat, input logic lap, input logic pp,
                       input logic ps, input logic ph, input logic [63:0] addr);
    req_valid      = 1'b1;
    req_kind       = kind;
    req_space      = space;
    dat_on         = dat;
    lap_en         = lap;
    priv_primary   = pp;
    priv_secondary = ps;
    priv_home      = ph;
    req_addr       = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_prefix(input logic [63:0] val);
    pfx_we    = 1'b1;
    pfx_wdata = val;
    @(posedge clk);
    @(negedge clk);
    pfx_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 valid", 64'(rsp_valid), 0);
    check(rsp_perm == 3'b000, "R1 perm", 64'(rsp_perm), 0);
    check(rsp_abs_addr == '0, "R1 abs", rsp_abs_addr, 0);
    check(!rsp_prot_exc && !rsp_wr_recheck && !rsp_bad_mode, "R1 flags",
          {61'd0, rsp_prot_exc, rsp_wr_recheck, rsp_bad_mode}, 0);
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h100);
    check(rsp_abs_addr == 64'h100, "R1 zero prefix", rsp_abs_addr, 64'h100);
    check(rsp_valid == 1'b1, "R2 valid after req", 64'(rsp_valid), 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 valid drops", 64'(rsp_valid), 0);

    // R6 low bits of the written prefix are discarded
    write_prefix(64'h6ABC);
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h10);
    check(rsp_abs_addr == 64'h6010, "R6 aligned prefix", rsp_abs_addr, 64'h6010);

    // Vector table with prefix 0x6000
    for (int i = 0; i < 19; i++) begin
      issue(VECS[i].kind, VECS[i].space, VECS[i].dat, VECS[i].lap,
            VECS[i].pp, VECS[i].ps, VECS[i].ph, 64'(VECS[i].addr));
      check(rsp_valid == 1'b1, $sformatf("R2 vec%0d valid", i), 64'(rsp_valid), 1);
      check(rsp_prot_exc == VECS[i].e_exc, $sformatf("R10 vec%0d exc", i),
            64'(rsp_prot_exc), 64'(VECS[i].e_exc));
      check(rsp_wr_recheck == VECS[i].e_rc, $sformatf("R11 vec%0d recheck", i),
            64'(rsp_wr_recheck), 64'(VECS[i].e_rc));
      check(rsp_bad_mode == VECS[i].e_bad, $sformatf("R13 vec%0d bad", i),
            64'(rsp_bad_mode), 64'(VECS[i].e_bad));
      check(rsp_perm == VECS[i].e_perm, $sformatf("R12 vec%0d perm", i),
            64'(rsp_perm), 64'(VECS[i].e_perm));
      check(rsp_abs_addr == 64'(VECS[i].e_abs), $sformatf("R3 vec%0d abs", i),
            rsp_abs_addr, 64'(VECS[i].e_abs));
    end

    // R6 write and request in the same cycle: old prefix used, new one next
    pfx_we    = 1'b1;
    pfx_wdata = 64'hA000;
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h10);
    pfx_we = 1'b0;
    check(rsp_abs_addr == 64'h6010, "R6 same-cycle old prefix", rsp_abs_addr, 64'h6010);
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h10);
    check(rsp_abs_addr == 64'hA010, "R6 next-cycle new prefix", rsp_abs_addr, 64'hA010);
    // R4 upper edge of the new prefix block and R5 just above it
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'hBFFF);
    check(rsp_abs_addr == 64'h1FFF, "R4 top of block", rsp_abs_addr, 64'h1FFF);
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'hC000);
    check(rsp_abs_addr == 64'hC000, "R5 past block", rsp_abs_addr, 64'hC000);
    // R5 the old prefix block now passes through
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h6010);
    check(rsp_abs_addr == 64'h6010, "R5 old block", rsp_abs_addr, 64'h6010);
    // R10 last byte of first window, fetch into window is permitted
    issue(2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1FF);
    check(rsp_prot_exc == 1'b1, "R10 byte 511", 64'(rsp_prot_exc), 1);
    issue(2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1FF);
    check(rsp_prot_exc == 1'b0 && rsp_perm == 3'b111, "R10 fetch allowed",
          {60'd0, rsp_prot_exc, rsp_perm}, 64'h7);
    // R7 store in window with guard off
    issue(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1000);
    check(!rsp_prot_exc && !rsp_wr_recheck, "R7 guard off",
          {62'd0, rsp_prot_exc, rsp_wr_recheck}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule